// File: doc/BRIEF.md
# GPIO Pin Bank with Atomic Set/Clear Control

This block controls a bank of general-purpose pins (32 by default) from a simple register port made of a write strobe, a word address, write data and combinational read data. Each pin has an output latch, a direction bit, a two-plane function select, a pull-off bit and a sleep-hold bit. The output latch and the direction bits are never written directly. Dedicated set and clear addresses change them, so software can flip single pins without a read-modify-write sequence.

The bank drives the pad-side signals for every pin: output value, output enable, pull enable, pull polarity and the two function-select planes. It also samples the pad inputs through a two-flop synchronizer. There is no separate pull-direction register. An enabled pull goes up when the pin's output latch is 1 and down when it is 0. While the `sleep` input is high, each pin whose hold bit is 0 is forced to input with its pull on. Pins whose hold bit is 1 keep their configured state.

Top module: `gpio_bank`

## Requirements
- R1: After reset, all pins are inputs (pad_oe=0), every latch is 0 (pad_out=0), pulls are on (pad_pull_en all 1), pulls point down (pad_pull_up=0), both function planes are 0, and the hold bits are 0.
- R2: A write to address 1 (output set) makes each latch bit that has a 1 in the write data equal 1. Latch bits with a 0 in the write data keep their value. A read of address 1 or 2 returns the latch.
- R3: A write to address 2 (output clear) makes each latch bit that has a 1 in the write data equal 0. All other latch bits keep their value.
- R4: A write to address 3 makes the pins marked by 1s into outputs, and a write to address 4 makes them inputs. Other pins keep their direction. Outside forced sleep, pad_oe equals the direction bits, and a read of address 3 or 4 returns them.
- R5: Addresses 5 (plane A) and 6 (plane B) are plain read/write registers and drive pad_fsel_a and pad_fsel_b. The code {B,A}=00 selects GPIO, A alone selects function A, B alone selects function B, and both together select function C.
- R6: Address 7 is the pull-off register. Outside forced sleep, pad_pull_en is the inverse of this register. pad_pull_up always equals the output latch.
- R7: A read of address 0 returns pad_in as it was two rising clock edges earlier. A change on pad_in is not visible after only one edge.
- R8: While sleep is 1, each pin whose hold bit (address 8, read/write) is 0 has pad_oe=0 and pad_pull_en=1. Each pin whose hold bit is 1 keeps its configured oe and pull enable.
- R9: Writes to address 0 and to addresses 9-15 change no register and no pad output. Reads of addresses 9-15 return 0.
- R10: Sleep changes no register contents. When sleep drops, the outputs again follow the configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe, one write per cycle |
| addr | input | 4 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| sleep | input | 1 | Applies the per-pin sleep policy while high |
| pad_in | input | 32 | Pad input levels (asynchronous) |
| pad_out | output | 32 | Output latch to the pads |
| pad_oe | output | 32 | Output enable per pin |
| pad_pull_en | output | 32 | Pull resistor enable per pin |
| pad_pull_up | output | 32 | Pull polarity, 1 = up |
| pad_fsel_a | output | 32 | Function-select plane A |
| pad_fsel_b | output | 32 | Function-select plane B |

## Verification
The assertions check the following on every cycle: set and clear writes landing on exactly the marked latch bits, direction and pull-off writes reaching the pads when no sleep is active, the two-edge latency of the input synchronizer, and that writes to the input address have no effect. Other behaviour shows only in the bench's scenarios. These include the sleep override mixed with per-pin hold bits, the four function codes on every pin, the readback of each address, and the unmapped addresses. The bench also runs a long random sequence of writes against a bench-side model of the registers.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned ADDR_W = 4;
  localparam logic [ADDR_W-1:0] A_PADS   = 4'd0;
  localparam logic [ADDR_W-1:0] A_OSET   = 4'd1;
  localparam logic [ADDR_W-1:0] A_OCLR   = 4'd2;
  localparam logic [ADDR_W-1:0] A_DSET   = 4'd3;
  localparam logic [ADDR_W-1:0] A_DCLR   = 4'd4;
  localparam logic [ADDR_W-1:0] A_FUNA   = 4'd5;
  localparam logic [ADDR_W-1:0] A_FUNB   = 4'd6;
  localparam logic [ADDR_W-1:0] A_NOPULL = 4'd7;
  localparam logic [ADDR_W-1:0] A_HOLD   = 4'd8;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_core_n = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [STAGES-1:0][W-1:0] st_q;
  logic [STAGES-1:0][W-1:0] st_d;

  always_comb begin
    st_d[0] = async_in;
    for (int s = 1; s < STAGES; s++) st_d[s] = st_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  assign sync_out = st_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_bank_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      out_q,
  output logic [W-1:0]      dir_q,
  output logic [W-1:0]      funa_q,
  output logic [W-1:0]      funb_q,
  output logic [W-1:0]      nopull_q,
  output logic [W-1:0]      hold_q
);
  logic [W-1:0] out_d, dir_d, funa_d, funb_d, nopull_d, hold_d;
  logic         out_en, dir_en, funa_en, funb_en, nopull_en, hold_en;

  always_comb begin
    out_en    = wr_en && (addr == A_OSET || addr == A_OCLR);
    dir_en    = wr_en && (addr == A_DSET || addr == A_DCLR);
    funa_en   = wr_en && (addr == A_FUNA);
    funb_en   = wr_en && (addr == A_FUNB);
    nopull_en = wr_en && (addr == A_NOPULL);
    hold_en   = wr_en && (addr == A_HOLD);
    out_d     = (addr == A_OSET) ? (out_q | wdata) : (out_q & ~wdata);
    dir_d     = (addr == A_DSET) ? (dir_q | wdata) : (dir_q & ~wdata);
    funa_d    = wdata;
    funb_d    = wdata;
    nopull_d  = wdata;
    hold_d    = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q    <= '0;
      dir_q    <= '0;
      funa_q   <= '0;
      funb_q   <= '0;
      nopull_q <= '0;
      hold_q   <= '0;
    end else begin
      if (out_en)    out_q    <= out_d;
      if (dir_en)    dir_q    <= dir_d;
      if (funa_en)   funa_q   <= funa_d;
      if (funb_en)   funb_q   <= funb_d;
      if (nopull_en) nopull_q <= nopull_d;
      if (hold_en)   hold_q   <= hold_d;
    end
  end
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
  parameter int unsigned W = 32
) (
  input  logic         sleep,
  input  logic [W-1:0] out_q,
  input  logic [W-1:0] dir_q,
  input  logic [W-1:0] nopull_q,
  input  logic [W-1:0] hold_q,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pad_pull_en,
  output logic [W-1:0] pad_pull_up
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    logic forced;
    assign forced         = sleep && !hold_q[i];
    assign pad_out[i]     = out_q[i];
    assign pad_oe[i]      = forced ? 1'b0 : dir_q[i];
    assign pad_pull_en[i] = forced ? 1'b1 : !nopull_q[i];
    assign pad_pull_up[i] = out_q[i];
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned W          = 32,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      rdata,
  input  logic              sleep,
  input  logic [W-1:0]      pad_in,
  output logic [W-1:0]      pad_out,
  output logic [W-1:0]      pad_oe,
  output logic [W-1:0]      pad_pull_en,
  output logic [W-1:0]      pad_pull_up,
  output logic [W-1:0]      pad_fsel_a,
  output logic [W-1:0]      pad_fsel_b
);
  logic         rst_core_n;
  logic [W-1:0] in_sync;
  logic [W-1:0] out_q, dir_q, funa_q, funb_q, nopull_q, hold_q;

  gpio_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_core_n(rst_core_n)
  );

  gpio_in_sync #(.W(W), .STAGES(SYNC_DEPTH)) u_insync (
    .clk(clk), .rst_n(rst_core_n), .async_in(pad_in), .sync_out(in_sync)
  );

  gpio_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_core_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .out_q(out_q), .dir_q(dir_q), .funa_q(funa_q), .funb_q(funb_q),
    .nopull_q(nopull_q), .hold_q(hold_q)
  );

  gpio_pad_mux #(.W(W)) u_mux (
    .sleep(sleep), .out_q(out_q), .dir_q(dir_q), .nopull_q(nopull_q),
    .hold_q(hold_q), .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_pull_en(pad_pull_en), .pad_pull_up(pad_pull_up)
  );

  assign pad_fsel_a = funa_q;
  assign pad_fsel_b = funb_q;

  always_comb begin
    unique case (addr)
      A_PADS:           rdata = in_sync;
      A_OSET, A_OCLR:   rdata = out_q;
      A_DSET, A_DCLR:   rdata = dir_q;
      A_FUNA:           rdata = funa_q;
      A_FUNB:           rdata = funb_q;
      A_NOPULL:         rdata = nopull_q;
      A_HOLD:           rdata = hold_q;
      default:          rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input logic              clk,
  input logic              rst_core_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [W-1:0]      wdata,
  input logic [W-1:0]      rdata,
  input logic              sleep,
  input logic [W-1:0]      pad_in,
  input logic [W-1:0]      pad_out,
  input logic [W-1:0]      pad_oe,
  input logic [W-1:0]      pad_pull_en
);
  logic [1:0] cyc_q;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)       cyc_q <= '0;
    else if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
  end

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_core_n)
    (cyc_q == 2'd0) |-> (pad_out == '0 && pad_oe == '0 && pad_pull_en == '1));

  assert_set_marks_R2: assert property (@(posedge clk) disable iff (!rst_core_n)
    (wr_en && addr == A_OSET) |=> ((pad_out & $past(wdata)) == $past(wdata)));

  assert_clr_marks_R3: assert property (@(posedge clk) disable iff (!rst_core_n)
    (wr_en && addr == A_OCLR) |=> ((pad_out & $past(wdata)) == '0));

  assert_dir_set_R4: assert property (@(posedge clk) disable iff (!rst_core_n)
    (wr_en && addr == A_DSET) |=> (sleep || ((pad_oe & $past(wdata)) == $past(wdata))));

  assert_nopull_R6: assert property (@(posedge clk) disable iff (!rst_core_n)
    (wr_en && addr == A_NOPULL) |=> (sleep || (pad_pull_en == ~$past(wdata))));

  assert_sync_delay_R7: assert property (@(posedge clk) disable iff (!rst_core_n)
    (cyc_q >= 2'd2 && addr == A_PADS) |-> (rdata == $past(pad_in, 2)));

  assert_pads_write_inert_R9: assert property (@(posedge clk) disable iff (!rst_core_n)
    (wr_en && addr == A_PADS) |=> (pad_out == $past(pad_out)));
endmodule

bind gpio_bank gpio_bank_chk #(.W(W)) u_chk (
  .clk(clk), .rst_core_n(rst_core_n), .wr_en(wr_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .sleep(sleep), .pad_in(pad_in),
  .pad_out(pad_out), .pad_oe(pad_oe), .pad_pull_en(pad_pull_en)
);

// File: tb/tb_gpio_bank.sv
module tb_gpio_bank;
  localparam int W = 32;
  logic clk = 1'b0;
  logic rst_n, wr_en, sleep;
  logic [3:0] addr;
  logic [W-1:0] wdata, rdata, pad_in;
  logic [W-1:0] pad_out, pad_oe, pad_pull_en, pad_pull_up, pad_fsel_a, pad_fsel_b;
  int total = 0, bad = 0;
  logic [W-1:0] m_out, m_dir, m_fa, m_fb, m_noff, m_hold;

  always #5 clk = ~clk;

  gpio_bank dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .sleep(sleep), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .pad_pull_en(pad_pull_en), .pad_pull_up(pad_pull_up),
    .pad_fsel_a(pad_fsel_a), .pad_fsel_b(pad_fsel_b)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = 4'd15;
    case (a)
      4'd1: m_out  = m_out | d;
      4'd2: m_out  = m_out & ~d;
      4'd3: m_dir  = m_dir | d;
      4'd4: m_dir  = m_dir & ~d;
      4'd5: m_fa   = d;
      4'd6: m_fb   = d;
      4'd7: m_noff = d;
      4'd8: m_hold = d;
      default: ;
    endcase
  endtask

  function automatic logic [W-1:0] exp_read(input logic [3:0] a);
    case (a)
      4'd0: return pad_in;
      4'd1, 4'd2: return m_out;
      4'd3, 4'd4: return m_dir;
      4'd5: return m_fa;
      4'd6: return m_fb;
      4'd7: return m_noff;
      4'd8: return m_hold;
      default: return '0;
    endcase
  endfunction

  task automatic rd(input string req, input logic [3:0] a);
    addr = a;
    #1;
    chk(req, rdata, exp_read(a));
    addr = 4'd15;
  endtask

  task automatic chk_pins(input string req);
    logic [W-1:0] forced;
    forced = sleep ? ~m_hold : '0;
    chk({req, " out"}, pad_out, m_out);
    chk({req, " oe"}, pad_oe, m_dir & ~forced);
    chk({req, " pull_en"}, pad_pull_en, ~m_noff | forced);
    chk({req, " pull_up R6"}, pad_pull_up, m_out);
    chk({req, " fsel_a R5"}, pad_fsel_a, m_fa);
    chk({req, " fsel_b R5"}, pad_fsel_b, m_fb);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; addr = 4'd15; wdata = '0; sleep = 1'b0; pad_in = '0;
    m_out = '0; m_dir = '0; m_fa = '0; m_fb = '0; m_noff = '0; m_hold = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk_pins("R1 reset");
    for (int a = 1; a <= 8; a++) rd("R1 reset readback", 4'(a));

    // R2 / R3: single-bit set and clear sweep over every pin
    for (int i = 0; i < W; i++) begin
      wr(4'd1, W'(1) << i);
      chk("R2 set one bit", pad_out, m_out);
      rd("R2 latch readback", 4'd1);
    end
    for (int i = 0; i < W; i += 2) begin
      wr(4'd2, W'(1) << i);
      chk("R3 clear one bit", pad_out, m_out);
      rd("R3 latch readback", 4'd2);
    end
    wr(4'd2, '1);
    chk("R3 clear all", pad_out, '0);

    // R4: direction sweep
    for (int i = 0; i < W; i++) begin
      wr(4'd3, W'(1) << i);
      chk("R4 dir set", pad_oe, m_dir);
    end
    wr(4'd4, 32'h0F0F_00FF);
    chk("R4 dir clear", pad_oe, m_dir);
    rd("R4 dir readback", 4'd4);

    // R5: every function code on every pin
    for (int i = 0; i < W; i++) begin
      for (int c = 0; c < 4; c++) begin
        wr(4'd5, c[0] ? (W'(1) << i) : '0);
        wr(4'd6, c[1] ? (W'(1) << i) : '0);
        chk("R5 code plane A", pad_fsel_a, W'(c[0]) << i);
        chk("R5 code plane B", pad_fsel_b, W'(c[1]) << i);
      end
    end

    // R6: pull off and pull polarity following the latch
    wr(4'd1, 32'hA5A5_3C3C);
    wr(4'd7, 32'h00FF_FF00);
    chk_pins("R6 pull");
    rd("R6 readback", 4'd7);

    // R7: input synchronizer latency
    for (int k = 0; k < 8; k++) begin
      logic [W-1:0] old_v;
      old_v = pad_in;
      @(negedge clk);
      pad_in = (k == 0) ? 32'hFFFF_FFFF : (32'h1 << (k * 4)) ^ 32'h5555_AAAA;
      @(negedge clk);
      addr = 4'd0; #1;
      chk("R7 not yet visible", rdata, old_v);
      @(negedge clk);
      rd("R7 visible after two edges", 4'd0);
    end

    // R8 / R10: sleep with mixed hold bits
    wr(4'd3, '1);
    wr(4'd7, 32'hFFFF_0000);
    wr(4'd8, 32'h1234_F0F0);
    @(negedge clk); sleep = 1'b1; #1;
    chk_pins("R8 sleep");
    chk("R8 forced pins input", pad_oe & ~m_hold, '0);
    chk("R8 forced pins pulled", pad_pull_en | m_hold, '1);
    for (int a = 1; a <= 8; a++) rd("R10 regs kept in sleep", 4'(a));
    @(negedge clk); sleep = 1'b0; #1;
    chk_pins("R10 wake");

    // R9: writes to input and unmapped addresses
    for (int a = 9; a < 16; a++) begin
      wr(4'(a), '1);
      chk_pins("R9 unmapped write");
      rd("R9 unmapped read", 4'(a));
    end
    wr(4'd0, 32'hDEAD_BEEF);
    chk_pins("R9 pads write");

    // Random mix against the model (R2-R6, R8, R9)
    for (int n = 0; n < 1500; n++) begin
      wr(4'($urandom_range(0, 15)), $urandom);
      sleep = ($urandom_range(0, 3) == 0); #1;
      chk_pins("R2-mix random");
      rd("R9-mix random readback", 4'($urandom_range(1, 15)));
    end
    sleep = 1'b0;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule